// File: doc/BRIEF.md
# Serial-Programmed Channel Select Controller

This block is the digital control section of an eight-way switch array. A short serial word selects the switch. The block runs on one free-running clock and an active-high chip select. Two data pins are bidirectional, and each is modelled as separate input, output and output-enable signals.

While chip select is high, one bit per rising clock edge is shifted into a four-bit register. The enable bit comes first, followed by the three select bits, most significant first. The oldest bit of that register drives the second data pin, so several controllers can be daisy-chained on one serial stream. While chip select is low, the data path reverses: the second pin is copied combinationally onto the first.

When chip select falls, the word is copied into a shadow register. The switch outputs then follow a break-before-make sequence. The channel that was on turns off after `TOFF` clock cycles, and the newly decoded channel turns on after `TON` cycles, with `TON` greater than `TOFF`.

Top module: `chsel_ser_ctrl`

## Requirements
- R1: While reset is asserted (rst_n low), sw_en is all zeros and d2_out is 0.
- R2: At each rising clk edge where cs is high, d1_in is shifted into the register, and d2_out presents the bit that was captured four shifting edges earlier. At edges where cs is low, no shift takes place and d2_out holds.
- R3: The word is taken from the first four bits shifted in, in this order: enable, B2, B1, B0. When enable is 1, exactly one sw_en bit is set, at index B2:B1:B0 (000 selects bit 0, 111 selects bit 7). When enable is 0, all sw_en bits are 0 whatever the select bits are.
- R4: Let E0 be the first rising edge that samples cs low after it was sampled high. The previously enabled output drops at edge E0+TOFF, and the new pattern appears at edge E0+TON. In between, all outputs are off, and two different channels are never on in consecutive cycles.
- R5: Once applied, sw_en stays unchanged until the next falling edge of cs, even while a new word is being shifted in.
- R6: While cs is high (after R9's first sample), d2_oe is 1 and d1_oe is 0.
- R7: While cs is low (after R9's first sample), d1_oe is 1, d2_oe is 0, and d1_out equals d2_in combinationally.
- R8: Two chained instances, with the near d2_out feeding the far d1_in and the far d1_out feeding the near d2_in, are programmed by one 8-bit burst. The far instance takes the first nibble and the near instance takes the second.
- R9: After reset is released, d1_oe and d2_oe both stay 0 until the first rising clk edge samples cs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock for shifting and for the switch delays |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select: high shifts the word in, falling edge applies it |
| d1_in | input | 1 | Level on the first data pin |
| d1_out | output | 1 | Value driven onto the first data pin |
| d1_oe | output | 1 | Drive enable for the first data pin |
| d2_in | input | 1 | Level on the second data pin |
| d2_out | output | 1 | Value driven onto the second data pin (oldest shift bit) |
| d2_oe | output | 1 | Drive enable for the second data pin |
| sw_en | output | 8 | One-hot switch enables |

## Verification
The assertions check four properties on every cycle: the switch vector is at most one-hot, no cycle passes directly from one channel to a different one, the outputs and the shadow word do not change outside their allowed windows, and the second data pin follows the shift register. The bench scenarios cover the rest. These are the exact cycle counts of the break-before-make sequence, the decode of every select value and of a disabled word, the combinational return path, the enable state before the first clock after reset, and the split of an 8-bit burst across two chained instances.

// File: rtl/chsel_ser_ctrl.sv
module chsel_ser_ctrl #(
  parameter int NCH  = 8,
  parameter int TON  = 5,
  parameter int TOFF = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs,
  input  logic           d1_in,
  output logic           d1_out,
  output logic           d1_oe,
  input  logic           d2_in,
  output logic           d2_out,
  output logic           d2_oe,
  output logic [NCH-1:0] sw_en
);
  localparam int SELW  = $clog2(NCH);
  localparam int WORDW = SELW + 1;
  localparam int CW    = $clog2(TON + 1);

  logic [WORDW-1:0] sr, shadow;
  logic [NCH-1:0]   dec;
  logic [CW-1:0]    cnt;
  logic             cs_q, seen, run;
  logic             fall;

  assign fall   = cs_q & ~cs;
  assign d2_out = sr[WORDW-1];
  assign d1_out = d2_in;
  assign d2_oe  = seen & cs;
  assign d1_oe  = seen & ~cs;

  always_comb begin
    dec = '0;
    if (shadow[WORDW-1]) dec[shadow[SELW-1:0]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b0;
      seen <= 1'b0;
      sr   <= '0;
    end else begin
      cs_q <= cs;
      seen <= 1'b1;
      if (cs) sr <= {sr[WORDW-2:0], d1_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      cnt    <= '0;
      run    <= 1'b0;
      sw_en  <= '0;
    end else if (fall) begin
      shadow <= sr;
      cnt    <= CW'(1);
      run    <= 1'b1;
    end else if (run) begin
      cnt <= cnt + CW'(1);
      if (cnt == CW'(TOFF)) sw_en <= '0;
      if (cnt == CW'(TON)) begin
        sw_en <= dec;
        run   <= 1'b0;
      end
    end
  end

  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sw_en));

  p_bbm_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en != '0 && $past(sw_en) != '0) |-> sw_en == $past(sw_en));

  p_hold_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(sw_en));

  p_hold_shadow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs |=> $stable(shadow));

  p_chain_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs) |-> d2_out == $past(sr[WORDW-2]));

endmodule

// File: tb/chsel_ser_ctrl_tb_top.sv
module chsel_ser_ctrl_tb_top;
  localparam int TON  = 5;
  localparam int TOFF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0;
  logic d1_in = 1'b0;
  logic back_in = 1'b0;
  logic n_d1_out, n_d1_oe, n_d2_out, n_d2_oe;
  logic f_d1_out, f_d1_oe, f_d2_out, f_d2_oe;
  logic [7:0] n_sw, f_sw;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  chsel_ser_ctrl #(.NCH(8), .TON(TON), .TOFF(TOFF)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .d1_in(d1_in),
    .d1_out(n_d1_out), .d1_oe(n_d1_oe), .d2_in(f_d1_out),
    .d2_out(n_d2_out), .d2_oe(n_d2_oe), .sw_en(n_sw));

  chsel_ser_ctrl #(.NCH(8), .TON(TON), .TOFF(TOFF)) far_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .d1_in(n_d2_out),
    .d1_out(f_d1_out), .d1_oe(f_d1_oe), .d2_in(back_in),
    .d2_out(f_d2_out), .d2_oe(f_d2_oe), .sw_en(f_sw));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic shift_word(input logic [3:0] w);
    cs = 1'b1;
    for (int i = 3; i >= 0; i--) begin
      d1_in = w[i];
      tick();
    end
  endtask

  task automatic apply_word(input logic [3:0] w);
    shift_word(w);
    cs = 1'b0;
    for (int i = 0; i <= TON; i++) tick();
  endtask

  function automatic logic [7:0] onehot(input logic [3:0] w);
    return w[3] ? (8'd1 << w[2:0]) : 8'd0;
  endfunction

  task automatic t_reset();
    chk(n_sw == 8'd0, "R1 sw_en in reset", n_sw, 0);
    chk(n_d2_out == 1'b0, "R1 d2_out in reset", n_d2_out, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    chk({n_d1_oe, n_d2_oe} == 2'b00, "R9 oe before first sample", {n_d1_oe, n_d2_oe}, 0);
    tick();
    chk({n_d1_oe, n_d2_oe} == 2'b10, "R9 oe after first sample", {n_d1_oe, n_d2_oe}, 2);
  endtask

  task automatic t_shift();
    logic [7:0] pat = 8'b1011_0010;
    cs = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      d1_in = pat[i];
      tick();
      if (i <= 4)
        chk(n_d2_out == pat[i+3], "R2 d2_out delayed four edges", n_d2_out, pat[i+3]);
    end
    chk({n_d1_oe, n_d2_oe} == 2'b01, "R6 oe with cs high", {n_d1_oe, n_d2_oe}, 1);
    cs = 1'b0;
    begin
      logic held = n_d2_out;
      for (int i = 0; i < 3; i++) begin
        d1_in = ~d1_in;
        tick();
        chk(n_d2_out == held, "R2 no shift with cs low", n_d2_out, held);
      end
    end
    for (int i = 0; i <= TON; i++) tick();
  endtask

  task automatic t_decode();
    for (int c = 0; c < 8; c++) begin
      apply_word({1'b1, 3'(c)});
      chk(n_sw == (8'd1 << c), "R3 channel decode", n_sw, 8'd1 << c);
    end
    apply_word(4'b0101);
    chk(n_sw == 8'd0, "R3 enable low gives all off", n_sw, 0);
  endtask

  task automatic t_bbm();
    logic [7:0] exp;
    apply_word(4'b1011);
    shift_word(4'b1110);
    chk(n_sw == onehot(4'b1011), "R5 hold while shifting", n_sw, onehot(4'b1011));
    cs = 1'b0;
    tick();
    chk(n_sw == onehot(4'b1011), "R4 old still on at E0", n_sw, onehot(4'b1011));
    for (int i = 1; i <= TON; i++) begin
      tick();
      exp = (i < TOFF) ? onehot(4'b1011) : (i < TON) ? 8'd0 : onehot(4'b1110);
      chk(n_sw == exp, "R4 break-before-make step", n_sw, exp);
    end
    cs = 1'b1;
    tick();
    tick();
    chk(n_sw == onehot(4'b1110), "R5 hold after cs rises", n_sw, onehot(4'b1110));
    cs = 1'b0;
    for (int i = 0; i <= TON; i++) tick();
  endtask

  task automatic t_return();
    cs = 1'b0;
    tick();
    chk({n_d1_oe, n_d2_oe} == 2'b10, "R7 oe with cs low", {n_d1_oe, n_d2_oe}, 2);
    back_in = 1'b1;
    #0.5;
    chk(n_d1_out == 1'b1, "R7 return path high", n_d1_out, 1);
    back_in = 1'b0;
    #0.5;
    chk(n_d1_out == 1'b0, "R7 return path low", n_d1_out, 0);
  endtask

  task automatic t_chain();
    logic [7:0] burst = {4'b1100, 4'b1001};
    cs = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      d1_in = burst[i];
      tick();
    end
    cs = 1'b0;
    for (int i = 0; i <= TON; i++) tick();
    chk(f_sw == onehot(4'b1100), "R8 far takes first nibble", f_sw, onehot(4'b1100));
    chk(n_sw == onehot(4'b1001), "R8 near takes second nibble", n_sw, onehot(4'b1001));
  endtask

  initial begin
    t_reset();
    t_shift();
    t_decode();
    t_bbm();
    t_return();
    t_chain();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule